// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands in four register-separated stages. Each operand is a sign bit, an unsigned fraction magnitude and a signed two's-complement exponent; its value is (−1)^sign × fraction × 2^exponent. Bit FRAC_W−1 of a fraction has weight one half, so a normalized non-zero fraction lies in [0.5, 1). Zero is encoded as a zero fraction.

The first stage compares the exponents. It keeps the larger one as the working exponent and forms the absolute difference. The second stage right-shifts the fraction that has the smaller exponent by that difference. The third stage combines the two magnitudes as a sum or a difference. The fourth stage renormalizes the result: a carry shifts it right one place, and otherwise a leading-zero count shifts it left and lowers the exponent by the same amount. Only truncation is done. Infinities, NaNs, denormals, rounding modes and exception flags are not handled.

A new operation can enter on every clock. A qualifying valid bit travels with each operation through the stages.

Top module: `fp_add_pipe`

## Requirements
- R1: An operation presented with valid_i high is sampled on a rising clock edge. Its result appears with valid_o high after the fourth rising edge, counting that sampling edge as the first. A new operation may be presented on every cycle. valid_o is low in cycles that correspond to no accepted operation.
- R2: While rst_ni is low, valid_o is low, and asserting reset discards every operation in flight.
- R3: The fraction with the smaller exponent is shifted right by the exponent difference before it is combined, and the bits shifted out are discarded. The result exponent starts from the larger input exponent.
- R4: If the exponent difference is FRAC_W or more, the smaller operand contributes zero, and the result equals the larger operand.
- R5: op_sub_i = 1 computes A − B by inverting B's sign; op_sub_i = 0 computes A + B. A sign bit of 1 means negative.
- R6: If the magnitude sum carries past bit FRAC_W−1, the result fraction is the sum shifted right by one with truncation, and the exponent is the larger input exponent plus one.
- R7: A non-zero, carry-free result is shifted left by its number of leading zeros, and the exponent is reduced by that count.
- R8: A zero result is output with frac_o = 0, exp_o = 0 and sign_o = 0.
- R9: When the effective signs differ, the result sign is the sign of the operand with the larger aligned magnitude.
- R10: Every non-zero result has frac_o bit FRAC_W−1 set, so it lies in [0.5, 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands are valid this cycle |
| op_sub_i | input | 1 | 1 = subtract B from A, 0 = add |
| a_sign_i | input | 1 | Sign of A (1 = negative) |
| a_frac_i | input | FRAC_W | Fraction magnitude of A |
| a_exp_i | input | EXP_W | Signed exponent of A |
| b_sign_i | input | 1 | Sign of B (1 = negative) |
| b_frac_i | input | FRAC_W | Fraction magnitude of B |
| b_exp_i | input | EXP_W | Signed exponent of B |
| valid_o | output | 1 | Result is valid |
| sign_o | output | 1 | Result sign |
| frac_o | output | FRAC_W | Result fraction magnitude |
| exp_o | output | EXP_W | Result signed exponent |

## Verification
On every cycle, the assertions check the following:
- the four-cycle valid latency;
- that a non-zero output is normalized and a zero output is canonical;
- the exponent increment after a carry;
- that an over-range alignment yields zero;
- the choice of sign after subtraction of magnitudes.

The arithmetic result depends on truncation during alignment, on the leading-zero shift amount and on whether the output is bit-exact. Only the bench's scenarios show these, by comparing each output against an independent model. The bench runs directed cancellation, carry, far-alignment and truncation cases, followed by back-to-back random operands. The discarding of operations in flight by a reset is also shown only by a bench scenario.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic [1:0] {
    NORM_SHL  = 2'd0,
    NORM_SHR  = 2'd1,
    NORM_ZERO = 2'd2
  } norm_e;
endpackage

// File: rtl/fpa_cmp.sv
module fpa_cmp #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8,
  localparam int TW    = EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_sub_i,
  input  logic              a_sign_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic              b_sign_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  output logic              valid_o,
  output logic              a_sign_o,
  output logic [FRAC_W-1:0] a_frac_o,
  output logic              b_sign_o,
  output logic [FRAC_W-1:0] b_frac_o,
  output logic              b_small_o,
  output logic [TW-1:0]     shift_o,
  output logic [EXP_W-1:0]  exp_o
);
  logic signed [TW-1:0] diff;
  logic                 b_small;
  logic [TW-1:0]        shift_d;
  logic [EXP_W-1:0]     exp_d;

  always_comb begin
    diff    = $signed({a_exp_i[EXP_W-1], a_exp_i}) - $signed({b_exp_i[EXP_W-1], b_exp_i});
    b_small = ~diff[TW-1];
    shift_d = b_small ? diff : -diff;
    exp_d   = b_small ? a_exp_i : b_exp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      a_sign_o  <= 1'b0;
      a_frac_o  <= '0;
      b_sign_o  <= 1'b0;
      b_frac_o  <= '0;
      b_small_o <= 1'b0;
      shift_o   <= '0;
      exp_o     <= '0;
    end else begin
      valid_o   <= valid_i;
      a_sign_o  <= a_sign_i;
      a_frac_o  <= a_frac_i;
      b_sign_o  <= b_sign_i ^ op_sub_i;
      b_frac_o  <= b_frac_i;
      b_small_o <= b_small;
      shift_o   <= shift_d;
      exp_o     <= exp_d;
    end
  end

  // larger exponent is kept as working exponent
  AST_EXP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($signed(exp_o) >= $signed($past(a_exp_i))) && ($signed(exp_o) >= $signed($past(b_exp_i)))); // R3
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8,
  localparam int TW    = EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              a_sign_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic              b_sign_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  input  logic              b_small_i,
  input  logic [TW-1:0]     shift_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic              valid_o,
  output logic              big_sign_o,
  output logic [FRAC_W-1:0] big_frac_o,
  output logic              small_sign_o,
  output logic [FRAC_W-1:0] small_frac_o,
  output logic [EXP_W-1:0]  exp_o
);
  localparam logic [TW-1:0] FW_T = TW'(FRAC_W);

  logic              big_sign, small_sign;
  logic [FRAC_W-1:0] big_frac, small_raw, small_sh;

  always_comb begin
    big_sign   = b_small_i ? a_sign_i : b_sign_i;
    big_frac   = b_small_i ? a_frac_i : b_frac_i;
    small_sign = b_small_i ? b_sign_i : a_sign_i;
    small_raw  = b_small_i ? b_frac_i : a_frac_i;
    small_sh   = (shift_i >= FW_T) ? '0 : (small_raw >> shift_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      big_sign_o   <= 1'b0;
      big_frac_o   <= '0;
      small_sign_o <= 1'b0;
      small_frac_o <= '0;
      exp_o        <= '0;
    end else begin
      valid_o      <= valid_i;
      big_sign_o   <= big_sign;
      big_frac_o   <= big_frac;
      small_sign_o <= small_sign;
      small_frac_o <= small_sh;
      exp_o        <= exp_i;
    end
  end

  AST_FAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shift_i >= FW_T) |=> (small_frac_o == '0)); // R4
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              big_sign_i,
  input  logic [FRAC_W-1:0] big_frac_i,
  input  logic              small_sign_i,
  input  logic [FRAC_W-1:0] small_frac_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic              valid_o,
  output logic              sign_o,
  output logic [FRAC_W:0]   sum_o,
  output logic [EXP_W-1:0]  exp_o
);
  logic            same, big_ge;
  logic [FRAC_W:0] sum_d;
  logic            sign_d;

  always_comb begin
    same   = (big_sign_i == small_sign_i);
    big_ge = (big_frac_i >= small_frac_i);
    if (same)        sum_d = {1'b0, big_frac_i} + {1'b0, small_frac_i};
    else if (big_ge) sum_d = {1'b0, big_frac_i - small_frac_i};
    else             sum_d = {1'b0, small_frac_i - big_frac_i};
    sign_d = (same || big_ge) ? big_sign_i : small_sign_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      sum_o   <= '0;
      exp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sign_o  <= sign_d;
      sum_o   <= sum_d;
      exp_o   <= exp_i;
    end
  end

  AST_SIGN_LARGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && big_sign_i != small_sign_i && small_frac_i > big_frac_i) |=> (sign_o == $past(small_sign_i))); // R9
  AST_SUB_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && big_sign_i != small_sign_i) |=> !sum_o[FRAC_W]); // R9
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm
  import fpa_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8,
  localparam int LZW   = $clog2(FRAC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sign_i,
  input  logic [FRAC_W:0]   sum_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic              valid_o,
  output logic              sign_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [EXP_W-1:0]  exp_o
);
  norm_e             mode;
  logic [LZW-1:0]    lz;
  logic              found;
  logic [FRAC_W-1:0] frac_d;
  logic [EXP_W-1:0]  exp_d;
  logic              sign_d;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!found && sum_i[i]) begin
        lz    = LZW'(FRAC_W - 1 - i);
        found = 1'b1;
      end
    end
    if (sum_i[FRAC_W]) mode = NORM_SHR;
    else if (!found)   mode = NORM_ZERO;
    else               mode = NORM_SHL;
    case (mode)
      NORM_SHR: begin
        frac_d = sum_i[FRAC_W:1];
        exp_d  = exp_i + EXP_W'(1);
        sign_d = sign_i;
      end
      NORM_ZERO: begin
        frac_d = '0;
        exp_d  = '0;
        sign_d = 1'b0;
      end
      default: begin
        frac_d = sum_i[FRAC_W-1:0] << lz;
        exp_d  = exp_i - EXP_W'(lz);
        sign_d = sign_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      frac_o  <= '0;
      exp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sign_o  <= sign_d;
      frac_o  <= frac_d;
      exp_o   <= exp_d;
    end
  end

  AST_NORM_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frac_o != '0) |-> frac_o[FRAC_W-1]); // R10
  AST_ZERO_CANON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frac_o == '0) |-> (!sign_o && exp_o == '0)); // R8
  AST_CARRY_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sum_i[FRAC_W]) |=> (exp_o == $past(exp_i) + EXP_W'(1))); // R6
  AST_SHL_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sum_i[FRAC_W] && sum_i != '0) |=> ($signed(exp_o) <= $signed($past(exp_i)))); // R7
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8,
  localparam int TW    = EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_sub_i,
  input  logic              a_sign_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic              b_sign_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  output logic              valid_o,
  output logic              sign_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [EXP_W-1:0]  exp_o
);
  logic              s1_valid, s1_a_sign, s1_b_sign, s1_b_small;
  logic [FRAC_W-1:0] s1_a_frac, s1_b_frac;
  logic [TW-1:0]     s1_shift;
  logic [EXP_W-1:0]  s1_exp;

  logic              s2_valid, s2_big_sign, s2_small_sign;
  logic [FRAC_W-1:0] s2_big_frac, s2_small_frac;
  logic [EXP_W-1:0]  s2_exp;

  logic              s3_valid, s3_sign;
  logic [FRAC_W:0]   s3_sum;
  logic [EXP_W-1:0]  s3_exp;

  fpa_cmp #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_cmp (
    .clk_i, .rst_ni, .valid_i, .op_sub_i,
    .a_sign_i, .a_frac_i, .a_exp_i, .b_sign_i, .b_frac_i, .b_exp_i,
    .valid_o(s1_valid), .a_sign_o(s1_a_sign), .a_frac_o(s1_a_frac),
    .b_sign_o(s1_b_sign), .b_frac_o(s1_b_frac), .b_small_o(s1_b_small),
    .shift_o(s1_shift), .exp_o(s1_exp)
  );

  fpa_align #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_align (
    .clk_i, .rst_ni, .valid_i(s1_valid),
    .a_sign_i(s1_a_sign), .a_frac_i(s1_a_frac),
    .b_sign_i(s1_b_sign), .b_frac_i(s1_b_frac),
    .b_small_i(s1_b_small), .shift_i(s1_shift), .exp_i(s1_exp),
    .valid_o(s2_valid), .big_sign_o(s2_big_sign), .big_frac_o(s2_big_frac),
    .small_sign_o(s2_small_sign), .small_frac_o(s2_small_frac), .exp_o(s2_exp)
  );

  fpa_addsub #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_addsub (
    .clk_i, .rst_ni, .valid_i(s2_valid),
    .big_sign_i(s2_big_sign), .big_frac_i(s2_big_frac),
    .small_sign_i(s2_small_sign), .small_frac_i(s2_small_frac), .exp_i(s2_exp),
    .valid_o(s3_valid), .sign_o(s3_sign), .sum_o(s3_sum), .exp_o(s3_exp)
  );

  fpa_norm #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_norm (
    .clk_i, .rst_ni, .valid_i(s3_valid), .sign_i(s3_sign),
    .sum_i(s3_sum), .exp_i(s3_exp),
    .valid_o, .sign_o, .frac_o, .exp_o
  );

  // cycles since reset, saturating, for the latency check
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst <= '0;
    else if (since_rst != 3'd4)   since_rst <= since_rst + 3'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (valid_o == $past(valid_i, 4))); // R1
endmodule

// File: tb/fp_add_pipe_tb_top.sv
module fp_add_pipe_tb_top;
  localparam int FW = 24;
  localparam int EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          valid_i = 0, op_sub_i = 0, a_sign_i = 0, b_sign_i = 0;
  logic [FW-1:0] a_frac_i = '0, b_frac_i = '0;
  logic [EW-1:0] a_exp_i = '0, b_exp_i = '0;
  logic          valid_o, sign_o;
  logic [FW-1:0] frac_o;
  logic [EW-1:0] exp_o;

  fp_add_pipe #(.FRAC_W(FW), .EXP_W(EW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .op_sub_i,
    .a_sign_i, .a_frac_i, .a_exp_i, .b_sign_i, .b_frac_i, .b_exp_i,
    .valid_o, .sign_o, .frac_o, .exp_o
  );

  int n_run = 0;
  int n_fail = 0;

  logic          hv[4];
  logic          hs[4];
  logic [FW-1:0] hf[4];
  logic [EW-1:0] he[4];
  string         ht[4];

  function automatic void model(input logic sa, input logic [EW-1:0] ea, input logic [FW-1:0] fa,
                                input logic sb, input logic [EW-1:0] eb, input logic [FW-1:0] fb,
                                input logic sub, output logic so, output logic [EW-1:0] eo,
                                output logic [FW-1:0] fo);
    longint xa, xb, big, sml, t, r, sum, mag;
    logic bs, ss;
    xa = longint'($signed(ea));
    xb = longint'($signed(eb));
    if (xa >= xb) begin
      big = longint'(fa); bs = sa; sml = longint'(fb); ss = sb ^ sub; t = xa - xb; r = xa;
    end else begin
      big = longint'(fb); bs = sb ^ sub; sml = longint'(fa); ss = sa; t = xb - xa; r = xb;
    end
    sml = (t >= FW) ? 0 : (sml >> t);
    sum = (bs ? -big : big) + (ss ? -sml : sml);
    if (sum == 0) begin
      so = 0; eo = '0; fo = '0;
      return;
    end
    so  = (sum < 0);
    mag = so ? -sum : sum;
    if (mag >= (longint'(1) << FW)) begin
      mag = mag >> 1;
      r   = r + 1;
    end else begin
      while (mag < (longint'(1) << (FW - 1))) begin
        mag = mag << 1;
        r   = r - 1;
      end
    end
    fo = mag[FW-1:0];
    eo = r[EW-1:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 4; i++) begin
      hv[i] = 0; hs[i] = 0; hf[i] = '0; he[i] = '0; ht[i] = "R1";
    end
  endtask

  // one cycle: check the output due now, then drive the next operation
  task automatic step(input logic v, input logic sa, input logic [EW-1:0] ea, input logic [FW-1:0] fa,
                      input logic sb, input logic [EW-1:0] eb, input logic [FW-1:0] fb,
                      input logic sub, input string tag);
    logic so;
    logic [EW-1:0] eo;
    logic [FW-1:0] fo;
    @(negedge clk);
    if (hv[3]) begin
      chk("R1", "valid", 64'(valid_o), 64'(1));
      chk(ht[3], "sign", 64'(sign_o), 64'(hs[3]));
      chk(ht[3], "frac", 64'(frac_o), 64'(hf[3]));
      chk(ht[3], "exp", 64'(exp_o), 64'(he[3]));
    end else begin
      chk("R1", "idle valid", 64'(valid_o), 64'(0));
    end
    for (int i = 3; i > 0; i--) begin
      hv[i] = hv[i-1]; hs[i] = hs[i-1]; hf[i] = hf[i-1]; he[i] = he[i-1]; ht[i] = ht[i-1];
    end
    model(sa, ea, fa, sb, eb, fb, sub, so, eo, fo);
    hv[0] = v; hs[0] = so; he[0] = eo; hf[0] = fo; ht[0] = tag;
    valid_i = v; op_sub_i = sub;
    a_sign_i = sa; a_exp_i = ea; a_frac_i = fa;
    b_sign_i = sb; b_exp_i = eb; b_frac_i = fb;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, '0, '0, 0, "R1");
  endtask

  function automatic logic [FW-1:0] rnd_frac();
    if ($urandom % 16 == 0) return '0;
    return {1'b1, FW'($urandom) >> 1};
  endfunction

  function automatic logic [EW-1:0] rnd_exp();
    return EW'(int'($urandom % 81) - 40);
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    clear_hist();
    repeat (3) @(negedge clk);
    chk("R2", "valid in reset", 64'(valid_o), 64'(0));
    rst_n = 1'b1;

    // R6: 0.5 + 0.5 at exp 0 -> 0.5 * 2^1
    step(1, 0, 8'd0, 24'h800000, 0, 8'd0, 24'h800000, 0, "R6");
    // R8: 0.75 - 0.75 -> canonical zero
    step(1, 0, 8'd5, 24'hC00000, 0, 8'd5, 24'hC00000, 1, "R8");
    // R8: -0.75 + 0.75 -> canonical zero (positive)
    step(1, 1, 8'd3, 24'hC00000, 0, 8'd3, 24'hC00000, 0, "R8");
    // R7: 0.75 - 0.5 -> 0.5 * 2^-1
    step(1, 0, 8'd0, 24'hC00000, 0, 8'd0, 24'h800000, 1, "R7");
    // R7: deep cancellation
    step(1, 0, 8'd2, 24'h800001, 0, 8'd2, 24'h800000, 1, "R7");
    // R4: exponent gap 30 >= FW
    step(1, 0, 8'd30, 24'hC00000, 0, 8'd0, 24'h800000, 0, "R4");
    // R4: gap exactly FW with B larger
    step(1, 1, 8'(-12), 24'hFFFFFF, 0, 8'd12, 24'hA00000, 0, "R4");
    // R9: 0.5 - 0.75 -> negative
    step(1, 0, 8'd0, 24'h800000, 0, 8'd0, 24'hC00000, 1, "R9");
    // R9: -0.9 + 0.6 -> negative from A
    step(1, 1, 8'd1, 24'hE66666, 0, 8'd1, 24'h999999, 0, "R9");
    // R3: truncated alignment
    step(1, 0, 8'd3, 24'h800000, 0, 8'd0, 24'hFFFFFF, 0, "R3");
    step(1, 0, 8'(-7), 24'hFFFFFF, 0, 8'(-4), 24'h800001, 0, "R3");
    // R5: subtract of negative B adds magnitudes
    step(1, 0, 8'd2, 24'hC00000, 1, 8'd2, 24'hC00000, 1, "R5");
    step(1, 0, 8'd2, 24'hC00000, 1, 8'd2, 24'hC00000, 0, "R8");
    // R10: zero operand with non-zero operand stays normalized
    step(1, 0, 8'd4, 24'h000000, 1, 8'(-3), 24'h912345, 0, "R10");
    idle(5);

    // R2: reset with pipeline full
    for (int i = 0; i < 3; i++)
      step(1, 0, 8'd1, 24'hC00000, 0, 8'd1, 24'h800000, 0, "R2");
    @(negedge clk);
    rst_n = 1'b0;
    valid_i = 0;
    #1;
    chk("R2", "valid after reset assert", 64'(valid_o), 64'(0));
    clear_hist();
    @(negedge clk);
    rst_n = 1'b1;
    idle(6);

    // random back-to-back traffic with idle gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) idle(1);
      else step(1, 1'($urandom), rnd_exp(), rnd_frac(), 1'($urandom), rnd_exp(), rnd_frac(),
                1'($urandom), "R10");
    end
    idle(6);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule